// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wakeup

This block turns an asynchronous serial line into parallel characters. A frame has one start bit, then 8 or 9 data bits sent least significant bit first, then one stop bit. The width is chosen at run time by a mode input. In 9-bit mode the ninth data bit goes to its own output bit, and the lower eight bits go to the data output. An external 16x oversampling tick sets the bit timing. The block does not generate the baud rate.

In a multi-drop network, a node that is not addressed can put its receiver to sleep. While asleep, completed characters are dropped and raise no flag. The receiver wakes on one of two events, chosen by a select input:
- an idle line, meaning one full frame time of continuous mark level;
- an address-marked character, meaning one whose most significant data bit is 1. That character is then received as a normal one.

A completed character sets a data-full flag. A read strobe clears it. A character that completes while the flag is still set raises an overrun and is discarded. An interrupt request summarises both flags when the interrupt enable is set.

Top module: `mpwake_rx`

## Requirements
- R1: With `nine_bit`=0, a frame of a low start bit, 8 data bits (LSB first) and a high stop bit sets `data_full` and presents the 8 bits on `rx_data`.
- R2: With `nine_bit`=1, a frame carries 9 data bits. Bits 0..7 go to `rx_data` and bit 8 goes to `rx_bit8`. An 8-bit frame leaves `rx_bit8` unchanged.
- R3: A start is recognised only on a high-to-low transition and is confirmed by a sample 8 ticks later, near mid-bit. A low pulse shorter than half a bit returns the receiver to waiting and yields no character.
- R4: A frame whose stop-bit sample is low is discarded. It leaves `data_full`, `overrun`, `rx_data` and the sleep state unchanged.
- R5: When a frame completes while `data_full` is 1 and no read strobe is present, `overrun` becomes 1 and `rx_data`/`rx_bit8` keep the earlier character.
- R6: A `rd_strobe` pulse clears `data_full` and `overrun`. A frame completing in the same cycle is accepted and sets `data_full` again.
- R7: `irq` is 1 exactly when `rx_irq_en` is 1 and `data_full` or `overrun` is 1.
- R8: A `sleep_set` pulse makes `asleep` 1. While asleep, a character that does not wake the receiver changes neither `data_full`, `overrun` nor `rx_data`.
- R9: With `wake_addr`=0, a sleeping receiver wakes (`asleep` back to 0) after continuous mark level for one frame time: 160 ticks in 8-bit mode, 176 in 9-bit mode. The count restarts at each low sample and at `sleep_set`. Later characters are received.
- R10: With `wake_addr`=1, a sleeping receiver wakes only on a valid character whose most significant data bit is 1 (bit 7 in 8-bit mode, bit 8 in 9-bit mode), and that character is received. An idle line does not wake it.
- R11: A synchronous active-low reset clears `data_full`, `overrun`, `asleep` and `irq`, and leaves `rx_data` and `rx_bit8` untouched. While `rx_en` is 0, no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| nine_bit | input | 1 | Frame width select: 0 = 8 data bits, 1 = 9 data bits |
| wake_addr | input | 1 | Wakeup select: 0 = idle line, 1 = address mark |
| rx_en | input | 1 | Receiver enable |
| sleep_set | input | 1 | One-cycle pulse that puts the receiver to sleep |
| rd_strobe | input | 1 | One-cycle pulse: character taken, clears flags |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rx_data | output | 8 | Last accepted character, bits 0..7 |
| rx_bit8 | output | 1 | Ninth data bit of the last accepted 9-bit character |
| data_full | output | 1 | A character is waiting to be read |
| overrun | output | 1 | A character was lost while `data_full` was set |
| asleep | output | 1 | Receiver is in sleep mode |
| irq | output | 1 | Receive interrupt request |

## Verification
A bit sampler that has lost its alignment shows up within one frame as wrong `rx_data` bits or a missing `data_full`. A stuck start-edge detector shows up as a missed character right after a framing error or a glitch. A wrong idle-count threshold shows up as `asleep` clearing after short gaps, or not clearing after a gap of fourteen bit times, so it is visible at the next flag sample. A wrong sleep flag makes characters appear or vanish at `data_full` on the very frame that follows. Wrong overrun handling is seen as overwritten `rx_data` on the second character sent without a read.

// File: rtl/mpwake_rx_pkg.sv
// Package: shared types and constants for the serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package mpwake_rx_pkg;
    // Receive sequencer phases
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } rx_phase_t;
endpackage

// File: rtl/mpwake_rx_sampler.sv
// Module: bit sampler and deserializer.
// Waits for a high-to-low edge on the synchronised line and confirms the
// start bit half a bit later. It then samples each data bit and the stop bit
// at mid-bit and pulses done_o with the assembled word.
// Assumes: tick_i is a one-cycle pulse at OVS times the bit rate, and line_i
// is already synchronised to clk.
module mpwake_rx_sampler
    import mpwake_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              nine_i,
    output logic              done_o,
    output logic              stop_ok_o,
    output logic              nine_o,
    output logic [DATA_W-1:0] data_o,
    output logic              b8_o
);
    localparam int CW   = $clog2(OVS);
    localparam int IW   = $clog2(DATA_W + 1);
    localparam int HALF = OVS / 2;

    rx_phase_t      phase;
    logic [CW-1:0]  tick_cnt;
    logic [IW-1:0]  bit_idx;
    logic [IW-1:0]  last_idx;
    logic [DATA_W:0] shreg;
    logic           prev_line;
    logic           mode_q;

    // Last data-bit index of the frame being received
    assign last_idx = mode_q ? IW'(DATA_W) : IW'(DATA_W - 1);

    // Sequencer: edge detect, start check, data and stop sampling
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            phase     <= PH_WAIT;
            tick_cnt  <= '0;
            bit_idx   <= '0;
            prev_line <= 1'b1;
            done_o    <= 1'b0;
            stop_ok_o <= 1'b0;
            mode_q    <= 1'b0;
            shreg     <= '0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                prev_line <= line_i;
                case (phase)
                    PH_WAIT: begin
                        if (prev_line && !line_i) begin
                            phase    <= PH_START;
                            tick_cnt <= '0;
                            mode_q   <= nine_i;
                        end
                    end
                    PH_START: begin
                        if (tick_cnt == CW'(HALF - 1)) begin
                            tick_cnt <= '0;
                            bit_idx  <= '0;
                            phase    <= line_i ? PH_WAIT : PH_DATA;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (tick_cnt == CW'(OVS - 1)) begin
                            tick_cnt <= '0;
                            shreg    <= {line_i, shreg[DATA_W:1]};
                            if (bit_idx == last_idx) begin
                                phase <= PH_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (tick_cnt == CW'(OVS - 1)) begin
                            tick_cnt  <= '0;
                            done_o    <= 1'b1;
                            stop_ok_o <= line_i;
                            phase     <= PH_WAIT;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // Word alignment: an 8-bit frame ends up one place higher in the shifter
    always_comb begin
        nine_o = mode_q;
        b8_o   = shreg[DATA_W];
        data_o = mode_q ? shreg[DATA_W-1:0] : shreg[DATA_W:1];
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !done_o); // R11
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= IW'(DATA_W)); // R1
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
endmodule

// File: rtl/mpwake_rx_idle.sv
// Module: idle-line detector.
// Counts ticks of continuous mark level. It pulses idle_o once when the
// count reaches one frame time (DATA_W+2 or DATA_W+3 bits of OVS ticks).
// Assumes: restart_i is a one-cycle pulse, and line_i is synchronised.
module mpwake_rx_idle #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic line_i,
    input  logic nine_i,
    input  logic restart_i,
    output logic idle_o
);
    localparam int T_SHORT = (DATA_W + 2) * OVS;
    localparam int T_LONG  = (DATA_W + 3) * OVS;
    localparam int NW      = $clog2(T_LONG + 1);

    logic [NW-1:0] mark_cnt;
    logic [NW-1:0] target;

    // Frame length in ticks for the current mode
    assign target = nine_i ? NW'(T_LONG) : NW'(T_SHORT);

    // Mark-run counter, saturating at the target with a single pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || restart_i) begin
            mark_cnt <= '0;
            idle_o   <= 1'b0;
        end else begin
            idle_o <= 1'b0;
            if (tick_i) begin
                if (!line_i) begin
                    mark_cnt <= '0;
                end else if (mark_cnt < target) begin
                    mark_cnt <= mark_cnt + 1'b1;
                    idle_o   <= (mark_cnt == target - 1'b1);
                end
            end
        end
    end

    AST_IDLE_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> $past(line_i)); // R9
    AST_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |=> !idle_o); // R9
endmodule

// File: rtl/mpwake_rx_flags.sv
// Module: character acceptance, sleep state and receive flags.
// Decides whether a completed frame is kept, dropped or lost to overrun.
// Tracks the sleep state and its two wakeup events, and forms the interrupt.
// Assumes: done_i, idle_i, sleep_set_i and rd_i are one-cycle pulses.
module mpwake_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              stop_ok_i,
    input  logic              nine_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              b8_i,
    input  logic              idle_i,
    input  logic              wake_addr_i,
    input  logic              sleep_set_i,
    input  logic              rd_i,
    input  logic              irq_en_i,
    output logic [DATA_W-1:0] data_o,
    output logic              b8_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              asleep_o,
    output logic              irq_o
);
    logic good, mark, wake_now, accept, lost;

    // Frame classification against the sleep state
    always_comb begin
        good     = done_i && stop_ok_i;
        mark     = nine_i ? b8_i : data_i[DATA_W-1];
        wake_now = asleep_o && ((wake_addr_i && good && mark) ||
                                (!wake_addr_i && idle_i));
        accept   = good && (!asleep_o || (wake_addr_i && mark));
        lost     = accept && full_o && !rd_i;
    end

    // Sleep state: set by request, cleared by the selected wakeup event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep_o <= 1'b0;
        end else if (sleep_set_i) begin
            asleep_o <= 1'b1;
        end else if (wake_now) begin
            asleep_o <= 1'b0;
        end
    end

    // Full and overrun flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else if (accept) begin
            full_o <= 1'b1;
            ovr_o  <= lost ? 1'b1 : (rd_i ? 1'b0 : ovr_o);
        end else if (rd_i) begin
            full_o <= 1'b0;
            ovr_o  <= 1'b0;
        end
    end

    // Data holding register, deliberately not reset
    always_ff @(posedge clk) begin
        if (accept && !lost) begin
            data_o <= data_i;
            if (nine_i) begin
                b8_o <= b8_i;
            end
        end
    end

    // Interrupt request
    assign irq_o = irq_en_i && (full_o || ovr_o);

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> full_o); // R5
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $stable(data_o)); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i) |=> !full_o); // R6
    AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> (!asleep_o || $past(sleep_set_i))); // R8
    AST_ADDR_WAKE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(asleep_o) && $past(wake_addr_i)) |-> $past(done_i)); // R10
    AST_BAD_STOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !stop_ok_i && !rd_i) |=> $stable(full_o)); // R4
endmodule

// File: rtl/mpwake_rx.sv
// Module: top of the asynchronous serial receiver with sleep/wakeup.
// Synchronises the line, then wires the sampler, the idle detector and the
// flag logic together.
// Assumes: tick16 comes from an external baud generator at 16x bit rate.
module mpwake_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              tick16,
    input  logic              nine_bit,
    input  logic              wake_addr,
    input  logic              rx_en,
    input  logic              sleep_set,
    input  logic              rd_strobe,
    input  logic              rx_irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              data_full,
    output logic              overrun,
    output logic              asleep,
    output logic              irq
);
    logic [SYNC_N-1:0] sync_q;
    logic              line;
    logic              f_done, f_stop_ok, f_nine, f_b8, idle_pulse;
    logic [DATA_W-1:0] f_data;

    // Line synchroniser, reset to mark level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], rx_in};
        end
    end
    assign line = sync_q[SYNC_N-1];

    mpwake_rx_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rx_en),
        .tick_i    (tick16),
        .line_i    (line),
        .nine_i    (nine_bit),
        .done_o    (f_done),
        .stop_ok_o (f_stop_ok),
        .nine_o    (f_nine),
        .data_o    (f_data),
        .b8_o      (f_b8)
    );

    mpwake_rx_idle #(.DATA_W(DATA_W), .OVS(OVS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rx_en),
        .tick_i    (tick16),
        .line_i    (line),
        .nine_i    (nine_bit),
        .restart_i (sleep_set),
        .idle_o    (idle_pulse)
    );

    mpwake_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (f_done),
        .stop_ok_i   (f_stop_ok),
        .nine_i      (f_nine),
        .data_i      (f_data),
        .b8_i        (f_b8),
        .idle_i      (idle_pulse),
        .wake_addr_i (wake_addr),
        .sleep_set_i (sleep_set),
        .rd_i        (rd_strobe),
        .irq_en_i    (rx_irq_en),
        .data_o      (rx_data),
        .b8_o        (rx_bit8),
        .full_o      (data_full),
        .ovr_o       (overrun),
        .asleep_o    (asleep),
        .irq_o       (irq)
    );

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (data_full || overrun)); // R7
endmodule

// File: tb/mpwake_rx_bench.sv
// Bench: directed corner cases followed by seeded random frames. Every
// frame is also fed to a behavioural model that computes the expected flags.
module mpwake_rx_bench;
    localparam int TPB = 64;   // clocks per bit: 16 ticks of 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       tick16 = 1'b0;
    logic       nine_bit = 1'b0, wake_addr = 1'b0, rx_en = 1'b0;
    logic       sleep_set = 1'b0, rd_strobe = 1'b0, rx_irq_en = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, data_full, overrun, asleep, irq;
    logic [1:0] tdiv = 2'd0;

    int total = 0, bad = 0;
    bit finished = 0;

    // model state
    bit         m_full = 0, m_ovr = 0, m_sleep = 0, m_dk = 0, m_bk = 0;
    logic [7:0] m_data;
    logic       m_b8;

    mpwake_rx u_mpwake_rx (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
        .nine_bit(nine_bit), .wake_addr(wake_addr), .rx_en(rx_en),
        .sleep_set(sleep_set), .rd_strobe(rd_strobe), .rx_irq_en(rx_irq_en),
        .rx_data(rx_data), .rx_bit8(rx_bit8), .data_full(data_full),
        .overrun(overrun), .asleep(asleep), .irq(irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    function automatic logic exp_irq();
        return rx_irq_en && (m_full || m_ovr);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "data_full", 32'(data_full), 32'(m_full));
        chk(req, "overrun", 32'(overrun), 32'(m_ovr));
        chk(req, "asleep", 32'(asleep), 32'(m_sleep));
        chk(req, "irq", 32'(irq), 32'(exp_irq()));
        if (m_dk) chk(req, "rx_data", 32'(rx_data), 32'(m_data));
        if (m_bk) chk(req, "rx_bit8", 32'(rx_bit8), 32'(m_b8));
    endtask

    task automatic hold(logic b, int clocks);
        rx_in = b;
        repeat (clocks) @(posedge clk);
        #1;
    endtask

    // one frame on the line, mirrored into the model
    task automatic send(logic [8:0] d, bit stop_ok);
        bit mark;
        hold(1'b0, TPB);
        for (int i = 0; i < (nine_bit ? 9 : 8); i++) hold(d[i], TPB);
        hold(stop_ok, TPB);
        if (!stop_ok) hold(1'b1, 2 * TPB);
        if (!rx_en || !stop_ok) return;
        mark = nine_bit ? d[8] : d[7];
        if (m_sleep) begin
            if (wake_addr && mark) m_sleep = 0;
            else return;
        end
        if (m_full) m_ovr = 1;
        else begin
            m_full = 1; m_data = d[7:0]; m_dk = 1;
            if (nine_bit) begin m_b8 = d[8]; m_bk = 1; end
        end
    endtask

    task automatic long_gap();
        hold(1'b1, 14 * TPB);
        if (m_sleep && !wake_addr) m_sleep = 0;
    endtask

    task automatic do_read();
        rd_strobe = 1'b1; @(posedge clk); #1; rd_strobe = 1'b0;
        m_full = 0; m_ovr = 0;
    endtask

    task automatic do_sleep();
        sleep_set = 1'b1; @(posedge clk); #1; sleep_set = 1'b0;
        m_sleep = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1357);
        repeat (4) @(posedge clk);
        #1;
        check_all("R11 reset");
        rst_n = 1'b1; rx_en = 1'b1;
        hold(1'b1, 2 * TPB);

        // R1 + R7: basic 8-bit frame and interrupt
        rx_irq_en = 1'b1;
        send(9'h0A5, 1); check_all("R1 8-bit frame / R7 irq");
        do_read(); check_all("R6 read clears / R7 irq low");

        // R2: ninth bit, then an 8-bit frame leaves it alone
        nine_bit = 1'b1; send(9'h13C, 1); check_all("R2 nine-bit capture"); do_read();
        nine_bit = 1'b0; send(9'h05A, 1); check_all("R2 bit8 held in 8-bit"); do_read();

        // R3: short low glitch, then a good frame
        hold(1'b0, 12); hold(1'b1, 2 * TPB); check_all("R3 glitch ignored");
        send(9'h081, 1); check_all("R3 frame after glitch"); do_read();

        // R4: bad stop bit discarded, receiver recovers
        send(9'h077, 0); check_all("R4 bad stop discarded");
        send(9'h011, 1); check_all("R4 recovery"); do_read();

        // R5: overrun keeps first character; R6 read clears both
        send(9'h022, 1); send(9'h033, 1); check_all("R5 overrun / R7 irq");
        do_read(); check_all("R6 read clears overrun");

        // R8/R10: address-mark wakeup
        wake_addr = 1'b1; do_sleep(); check_all("R8 sleep set");
        send(9'h012, 1); check_all("R8 non-address dropped");
        long_gap(); check_all("R10 idle does not wake");
        send(9'h09E, 1); check_all("R10 address char wakes and is kept"); do_read();
        nine_bit = 1'b1; do_sleep();
        send(9'h080, 1); check_all("R10 bit7 not a mark in 9-bit");
        send(9'h105, 1); check_all("R10 bit8 mark wakes"); do_read();
        nine_bit = 1'b0;

        // R8/R9: idle-line wakeup
        wake_addr = 1'b0; do_sleep();
        send(9'h044, 1); check_all("R8 asleep drops char");
        long_gap(); check_all("R9 idle wakes");
        send(9'h066, 1); check_all("R9 receive after idle wake"); do_read();

        // R11: disabled receiver takes nothing
        rx_en = 1'b0; send(9'h055, 1); check_all("R11 disabled");
        rx_en = 1'b1; hold(1'b1, TPB);

        // random mix
        for (int it = 0; it < 48; it++) begin
            nine_bit  = 1'($urandom % 2);
            wake_addr = 1'($urandom % 2);
            rx_irq_en = 1'($urandom % 2);
            if ($urandom % 4 == 0) do_sleep();
            send(9'($urandom), ($urandom % 8) != 0);
            if ($urandom % 3 == 0) long_gap();
            check_all("R1 R2 R5 R8 R9 R10 random");
            if ($urandom % 2 == 0) begin
                do_read(); check_all("R6 random read");
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule